// File: doc/BRIEF.md
# Interval Utilisation and Frequency Calculator

This block turns three free-running 64-bit event counts into per-interval figures. A wall-clock stamp count runs all the time. A reference count advances at a fixed rate only while the core is active. An actual count advances at the core's real clock rate only while active. On each interval strobe the block latches all three counts and subtracts the counts it latched at the previous accepted strobe. From those differences it derives three results: the share of wall time spent active in percent, the mean clock rate in MHz over the whole interval, and the mean clock rate in MHz over the active portion only.

All quotients come from a single shift-subtract divider that is used four times in turn. The frequency used to scale the active-only rate can come from an input in MHz. It can also be estimated as the stamp difference divided by the interval length in microseconds. The intended interval is one second (1,000,000 µs), but any nonzero length works. Results and their valid flag stay registered and unchanged until the next accepted strobe.

Top module: `interval_perf_calc`

## Requirements
- R1: Each difference is the current latched count minus the previous latched count, modulo 2^64, so a counter that wraps past zero gives the true increment.
- R2: `busy_pct` = floor(Δref × 100 / Δstamp); it is 0 when Δstamp is 0.
- R3: `avg_mhz` = floor(Δact / intv_us). It is 0 when `intv_us` is 0, and also 0 when the core was idle for the whole interval (Δact = 0).
- R4: `active_mhz` = floor(base × Δact / Δref); it is 0 when Δref is 0.
- R5: When `base_from_stamp` is 0, base is `base_mhz`. When it is 1, base is floor(Δstamp / intv_us), clipped to 65535, or 0 when `intv_us` is 0. Both inputs are sampled at the accepted strobe.
- R6: A result whose exact quotient exceeds 2^32−1 is reported as 2^32−1 (0xFFFFFFFF).
- R7: The first accepted strobe after reset only latches a baseline: `res_valid` stays 0 and no calculation runs.
- R8: `res_valid` goes to 0 at the clock edge that samples an accepted strobe. It goes to 1 with all three results when the calculation finishes. Results and `res_valid` then stay unchanged until the next accepted strobe, whatever the counters do.
- R9: A strobe that arrives while a calculation is running is ignored. Nothing is latched, so the next accepted interval is measured from the last accepted sample.
- R10: After reset, `res_valid` is 0 and all three results are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| intv_tick | input | 1 | Interval strobe, one cycle wide |
| stamp_cnt | input | 64 | Constant-rate wall-clock count |
| ref_cnt | input | 64 | Fixed-rate count, active time only |
| act_cnt | input | 64 | Real-clock count, active time only |
| base_mhz | input | 16 | Base frequency in MHz |
| base_from_stamp | input | 1 | 1: derive base from Δstamp / intv_us |
| intv_us | input | 32 | Interval length in microseconds |
| busy_pct | output | 32 | Active share in percent |
| avg_mhz | output | 32 | Mean frequency over the interval |
| active_mhz | output | 32 | Mean frequency while active |
| res_valid | output | 1 | Results valid |

## Verification
The assertions take for granted that the strobe is a single-cycle pulse. They also assume that the counts, base and interval length matter only in the cycle the strobe is accepted. Between strobes the inputs may wander freely. The hold check relies on that: it requires the outputs to stay stable while the bench deliberately changes the counters with no strobe. The bench drives every strobe for exactly one cycle on the falling edge. It fires a second strobe during a running calculation only in the scenario meant to show that such a strobe is dropped.

// File: rtl/perf_calc_pkg.sv
package perf_calc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PCT,
    ST_AVG,
    ST_BASE,
    ST_ACT
  } calc_st_t;
  localparam int unsigned PCT_SCALE = 100;
endpackage

// File: rtl/sample_delta.sv
module sample_delta #(
  parameter int CNT_W  = 64,
  parameter int BASE_W = 16,
  parameter int IV_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [CNT_W-1:0]  stamp_in,
  input  logic [CNT_W-1:0]  ref_in,
  input  logic [CNT_W-1:0]  act_in,
  input  logic [BASE_W-1:0] base_in,
  input  logic              sel_in,
  input  logic [IV_W-1:0]   iv_in,
  output logic [CNT_W-1:0]  d_stamp,
  output logic [CNT_W-1:0]  d_ref,
  output logic [CNT_W-1:0]  d_act,
  output logic [BASE_W-1:0] base_q,
  output logic              sel_q,
  output logic [IV_W-1:0]   iv_q,
  output logic              rdy
);
  logic [CNT_W-1:0] prev_stamp, prev_ref, prev_act;
  logic             primed;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_stamp <= '0;
      prev_ref   <= '0;
      prev_act   <= '0;
      d_stamp    <= '0;
      d_ref      <= '0;
      d_act      <= '0;
      base_q     <= '0;
      sel_q      <= 1'b0;
      iv_q       <= '0;
      primed     <= 1'b0;
      rdy        <= 1'b0;
    end else begin
      rdy <= 1'b0;
      if (take) begin
        prev_stamp <= stamp_in;
        prev_ref   <= ref_in;
        prev_act   <= act_in;
        d_stamp    <= stamp_in - prev_stamp;
        d_ref      <= ref_in - prev_ref;
        d_act      <= act_in - prev_act;
        base_q     <= base_in;
        sel_q      <= sel_in;
        iv_q       <= iv_in;
        primed     <= 1'b1;
        rdy        <= primed;
      end
    end
  end

  // R9: without an accepted strobe the latched samples do not move
  p_hold_prev_r9: assert property (@(posedge clk) disable iff (rst)
    !take |=> $stable(prev_stamp) && $stable(prev_ref) && $stable(prev_act));

  // R7: the baseline strobe launches no calculation
  p_first_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    take && !primed |=> !rdy);

  // R1: difference plus old sample equals new sample modulo 2^CNT_W
  p_wrap_delta_r1: assert property (@(posedge clk) disable iff (rst)
    rdy |-> (CNT_W'(d_stamp + $past(prev_stamp)) == prev_stamp)
         && (CNT_W'(d_ref + $past(prev_ref)) == prev_ref)
         && (CNT_W'(d_act + $past(prev_act)) == prev_act));
endmodule

// File: rtl/seq_divider.sv
module seq_divider #(
  parameter int NUM_W = 80,
  parameter int DEN_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             done,
  output logic [NUM_W-1:0] quo
);
  localparam int CW = $clog2(NUM_W + 1);

  logic [DEN_W-1:0] rem, den_q;
  logic [NUM_W-1:0] work;
  logic [CW-1:0]    cnt;
  logic             busy;
  logic [DEN_W:0]   trial, diff;
  logic             fits;

  always_comb begin
    trial = {rem, work[NUM_W-1]};
    diff  = trial - {1'b0, den_q};
    fits  = trial >= {1'b0, den_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem   <= '0;
      den_q <= '0;
      work  <= '0;
      cnt   <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        if (den == '0) begin
          work <= '0;
          done <= 1'b1;
        end else begin
          den_q <= den;
          work  <= num;
          rem   <= '0;
          cnt   <= CW'(NUM_W);
          busy  <= 1'b1;
        end
      end else if (busy) begin
        rem  <= fits ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
        work <= {work[NUM_W-2:0], fits};
        cnt  <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign quo = work;

  // R2/R4: a zero divisor gives a zero quotient instead of a fault
  p_zero_den_r2: assert property (@(posedge clk) disable iff (rst)
    start && !busy && (den == '0) |=> done && (quo == '0));

  // R4: the partial remainder never reaches the divisor
  p_rem_bound_r4: assert property (@(posedge clk) disable iff (rst)
    busy |-> rem < den_q);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/calc_ctrl.sv
module calc_ctrl
  import perf_calc_pkg::*;
#(
  parameter int CNT_W  = 64,
  parameter int BASE_W = 16,
  parameter int IV_W   = 32,
  parameter int OUT_W  = 32,
  localparam int NUM_W = CNT_W + BASE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic              rdy,
  input  logic [CNT_W-1:0]  d_stamp,
  input  logic [CNT_W-1:0]  d_ref,
  input  logic [CNT_W-1:0]  d_act,
  input  logic [BASE_W-1:0] base_q,
  input  logic              sel_q,
  input  logic [IV_W-1:0]   iv_q,
  input  logic              div_done,
  input  logic [NUM_W-1:0]  div_quo,
  output logic              div_start,
  output logic [NUM_W-1:0]  div_num,
  output logic [CNT_W-1:0]  div_den,
  output logic [OUT_W-1:0]  pct_o,
  output logic [OUT_W-1:0]  avg_o,
  output logic [OUT_W-1:0]  act_o,
  output logic              valid_o,
  output logic              idle_o
);
  calc_st_t          st;
  logic              kick;
  logic [BASE_W-1:0] base_use;
  logic [OUT_W-1:0]  quo_out;
  logic [BASE_W-1:0] quo_base;

  always_comb begin
    quo_out  = (|div_quo[NUM_W-1:OUT_W])  ? '1 : div_quo[OUT_W-1:0];
    quo_base = (|div_quo[NUM_W-1:BASE_W]) ? '1 : div_quo[BASE_W-1:0];
  end

  always_comb begin
    div_num = '0;
    div_den = '0;
    case (st)
      ST_PCT: begin
        div_num = NUM_W'(d_ref) * NUM_W'(PCT_SCALE);
        div_den = d_stamp;
      end
      ST_AVG: begin
        div_num = NUM_W'(d_act);
        div_den = CNT_W'(iv_q);
      end
      ST_BASE: begin
        div_num = NUM_W'(d_stamp);
        div_den = CNT_W'(iv_q);
      end
      ST_ACT: begin
        div_num = NUM_W'(d_act) * NUM_W'(base_use);
        div_den = d_ref;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      kick     <= 1'b0;
      base_use <= '0;
      pct_o    <= '0;
      avg_o    <= '0;
      act_o    <= '0;
      valid_o  <= 1'b0;
    end else begin
      kick <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (take) valid_o <= 1'b0;
          if (rdy) begin
            base_use <= base_q;
            st       <= ST_PCT;
            kick     <= 1'b1;
          end
        end
        ST_PCT: if (div_done) begin
          pct_o <= quo_out;
          st    <= ST_AVG;
          kick  <= 1'b1;
        end
        ST_AVG: if (div_done) begin
          avg_o <= quo_out;
          st    <= sel_q ? ST_BASE : ST_ACT;
          kick  <= 1'b1;
        end
        ST_BASE: if (div_done) begin
          base_use <= quo_base;
          st       <= ST_ACT;
          kick     <= 1'b1;
        end
        ST_ACT: if (div_done) begin
          act_o   <= quo_out;
          valid_o <= 1'b1;
          st      <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign div_start = kick;
  assign idle_o    = (st == ST_IDLE) && !rdy;

  // R8: results hold until a strobe is accepted
  p_valid_hold_r8: assert property (@(posedge clk) disable iff (rst)
    valid_o && !take |=> valid_o && $stable(pct_o) && $stable(avg_o) && $stable(act_o));

  // R8: an accepted strobe withdraws valid on the same edge
  p_valid_drop_r8: assert property (@(posedge clk) disable iff (rst)
    valid_o && take |=> !valid_o);

  // R9: no strobe is accepted mid-calculation
  p_no_take_busy_r9: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE) |-> !take);
endmodule

// File: rtl/interval_perf_calc.sv
module interval_perf_calc #(
  parameter int CNT_W  = 64,
  parameter int BASE_W = 16,
  parameter int IV_W   = 32,
  parameter int OUT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              intv_tick,
  input  logic [CNT_W-1:0]  stamp_cnt,
  input  logic [CNT_W-1:0]  ref_cnt,
  input  logic [CNT_W-1:0]  act_cnt,
  input  logic [BASE_W-1:0] base_mhz,
  input  logic              base_from_stamp,
  input  logic [IV_W-1:0]   intv_us,
  output logic [OUT_W-1:0]  busy_pct,
  output logic [OUT_W-1:0]  avg_mhz,
  output logic [OUT_W-1:0]  active_mhz,
  output logic              res_valid
);
  localparam int NUM_W = CNT_W + BASE_W;

  logic              take, idle, rdy, sel_q, div_start, div_done;
  logic [CNT_W-1:0]  d_stamp, d_ref, d_act, div_den;
  logic [BASE_W-1:0] base_q;
  logic [IV_W-1:0]   iv_q;
  logic [NUM_W-1:0]  div_num, div_quo;

  assign take = intv_tick && idle;

  sample_delta #(.CNT_W(CNT_W), .BASE_W(BASE_W), .IV_W(IV_W)) u_samp (
    .clk(clk), .rst(rst), .take(take),
    .stamp_in(stamp_cnt), .ref_in(ref_cnt), .act_in(act_cnt),
    .base_in(base_mhz), .sel_in(base_from_stamp), .iv_in(intv_us),
    .d_stamp(d_stamp), .d_ref(d_ref), .d_act(d_act),
    .base_q(base_q), .sel_q(sel_q), .iv_q(iv_q), .rdy(rdy)
  );

  calc_ctrl #(.CNT_W(CNT_W), .BASE_W(BASE_W), .IV_W(IV_W), .OUT_W(OUT_W)) u_ctrl (
    .clk(clk), .rst(rst), .take(take), .rdy(rdy),
    .d_stamp(d_stamp), .d_ref(d_ref), .d_act(d_act),
    .base_q(base_q), .sel_q(sel_q), .iv_q(iv_q),
    .div_done(div_done), .div_quo(div_quo),
    .div_start(div_start), .div_num(div_num), .div_den(div_den),
    .pct_o(busy_pct), .avg_o(avg_mhz), .act_o(active_mhz),
    .valid_o(res_valid), .idle_o(idle)
  );

  seq_divider #(.NUM_W(NUM_W), .DEN_W(CNT_W)) u_div (
    .clk(clk), .rst(rst), .start(div_start),
    .num(div_num), .den(div_den), .done(div_done), .quo(div_quo)
  );

  // R10: nothing is valid in the cycle after reset
  p_reset_clear_r10: assert property (@(posedge clk)
    rst |=> !res_valid && (busy_pct == '0) && (avg_mhz == '0) && (active_mhz == '0));
endmodule

// File: tb/sim_interval_perf_calc.sv
module sim_interval_perf_calc;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        intv_tick = 1'b0;
  logic [63:0] stamp_cnt = '0, ref_cnt = '0, act_cnt = '0;
  logic [15:0] base_mhz = 16'd2000;
  logic        base_from_stamp = 1'b0;
  logic [31:0] intv_us = 32'd1000;
  logic [31:0] busy_pct, avg_mhz, active_mhz;
  logic        res_valid;

  int n_chk = 0;
  int n_bad = 0;
  logic [63:0] p_st = '0, p_rf = '0, p_ac = '0;

  always #4 clk = ~clk;

  interval_perf_calc u0 (
    .clk(clk), .rst(rst), .intv_tick(intv_tick),
    .stamp_cnt(stamp_cnt), .ref_cnt(ref_cnt), .act_cnt(act_cnt),
    .base_mhz(base_mhz), .base_from_stamp(base_from_stamp), .intv_us(intv_us),
    .busy_pct(busy_pct), .avg_mhz(avg_mhz), .active_mhz(active_mhz),
    .res_valid(res_valid)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] clip32(input logic [127:0] v);
    return (v > 128'hFFFF_FFFF) ? 32'hFFFF_FFFF : v[31:0];
  endfunction

  task automatic tick(input logic [63:0] s, input logic [63:0] r, input logic [63:0] a);
    @(negedge clk);
    stamp_cnt = s; ref_cnt = r; act_cnt = a;
    intv_tick = 1'b1;
    @(negedge clk);
    intv_tick = 1'b0;
  endtask

  task automatic wait_valid(input string req);
    int k = 0;
    while (!res_valid && k < 2000) begin
      @(negedge clk);
      k++;
    end
    chk(req, {63'd0, res_valid}, 64'd1);
  endtask

  task automatic check_results(input logic [63:0] ds, input logic [63:0] dr, input logic [63:0] da);
    logic [127:0] bs;
    logic [31:0] e_pct, e_avg, e_act;
    e_pct = (ds == 0) ? 32'd0 : clip32(({64'd0, dr} * 128'd100) / {64'd0, ds});
    e_avg = (intv_us == 0) ? 32'd0 : clip32({64'd0, da} / {96'd0, intv_us});
    if (base_from_stamp) begin
      bs = (intv_us == 0) ? 128'd0 : ({64'd0, ds} / {96'd0, intv_us});
      if (bs > 128'd65535) bs = 128'd65535;
    end else bs = {112'd0, base_mhz};
    e_act = (dr == 0) ? 32'd0 : clip32((bs * {64'd0, da}) / {64'd0, dr});
    chk("R2 busy_pct", {32'd0, busy_pct}, {32'd0, e_pct});
    chk("R3 avg_mhz", {32'd0, avg_mhz}, {32'd0, e_avg});
    chk("R4/R5 active_mhz", {32'd0, active_mhz}, {32'd0, e_act});
  endtask

  // one accepted interval: strobe, valid drop, completion, result check
  task automatic step(input string req, input logic [63:0] s, input logic [63:0] r, input logic [63:0] a);
    tick(s, r, a);
    chk("R8 valid drops after strobe", {63'd0, res_valid}, 64'd0);
    wait_valid(req);
    check_results(s - p_st, r - p_rf, a - p_ac);
    p_st = s; p_rf = r; p_ac = a;
  endtask

  task automatic t_reset;
    chk("R10 valid", {63'd0, res_valid}, 64'd0);
    chk("R10 results", {32'd0, busy_pct | avg_mhz | active_mhz}, 64'd0);
  endtask

  task automatic t_baseline;
    tick(64'd1000, 64'd500, 64'd800);
    p_st = 64'd1000; p_rf = 64'd500; p_ac = 64'd800;
    repeat (600) @(negedge clk);
    chk("R7 no valid after baseline", {63'd0, res_valid}, 64'd0);
  endtask

  task automatic t_basic;
    base_from_stamp = 1'b0; base_mhz = 16'd2000; intv_us = 32'd1000;
    step("R2 basic", p_st + 64'd2_000_000, p_rf + 64'd1_500_000, p_ac + 64'd3_000_000);
    chk("R2 expect 75", {32'd0, busy_pct}, 64'd75);
  endtask

  task automatic t_hold;
    logic [31:0] a, b, c;
    a = busy_pct; b = avg_mhz; c = active_mhz;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      stamp_cnt = stamp_cnt + 64'd977; act_cnt = act_cnt + 64'd13;
    end
    chk("R8 hold valid", {63'd0, res_valid}, 64'd1);
    chk("R8 hold results", {busy_pct, avg_mhz ^ active_mhz}, {a, b ^ c});
  endtask

  task automatic t_wrap;
    logic [63:0] top;
    top = 64'hFFFF_FFFF_FFFF_F000;
    step("R1 near top", top, top - 64'd100, top - 64'd200);
    step("R1 wrapped", top + 64'd8000, top - 64'd100 + 64'd6000, top - 64'd200 + 64'd9000);
    chk("R1 wrap pct 75", {32'd0, busy_pct}, 64'd75);
  endtask

  task automatic t_stamp_base;
    base_from_stamp = 1'b1; intv_us = 32'd1000;
    step("R5 derived base", p_st + 64'd3_000_000, p_rf + 64'd1_000_000, p_ac + 64'd2_500_000);
    chk("R5 active 7500", {32'd0, active_mhz}, 64'd7500);
    base_from_stamp = 1'b0;
  endtask

  task automatic t_idle;
    step("R3 idle interval", p_st + 64'd1_000_000, p_rf, p_ac);
    chk("R3 idle avg 0", {32'd0, avg_mhz}, 64'd0);
    chk("R4 zero ref gives 0", {32'd0, active_mhz}, 64'd0);
  endtask

  task automatic t_zero_stamp;
    base_from_stamp = 1'b1;
    step("R2 zero stamp", p_st, p_rf + 64'd5, p_ac + 64'd5);
    chk("R2 zero stamp pct 0", {32'd0, busy_pct}, 64'd0);
    base_from_stamp = 1'b0;
  endtask

  task automatic t_sat;
    intv_us = 32'd1;
    step("R6 saturate", p_st + (64'd1 << 40), p_rf + (64'd1 << 40), p_ac + (64'd1 << 40));
    chk("R6 avg clipped", {32'd0, avg_mhz}, 64'hFFFF_FFFF);
    intv_us = 32'd1000;
  endtask

  task automatic t_ignore;
    logic [63:0] as, ar, aa;
    as = p_st + 64'd400_000; ar = p_rf + 64'd100_000; aa = p_ac + 64'd900_000;
    tick(as, ar, aa);
    repeat (3) @(negedge clk);
    tick(as + 64'd77_777, ar + 64'd5, aa + 64'd3);
    wait_valid("R9 first interval");
    check_results(as - p_st, ar - p_rf, aa - p_ac);
    chk("R9 pct from first strobe", {32'd0, busy_pct}, 64'd25);
    p_st = as; p_rf = ar; p_ac = aa;
    step("R9 next measured from accepted", p_st + 64'd1000, p_rf + 64'd500, p_ac + 64'd700);
    chk("R9 pct 50", {32'd0, busy_pct}, 64'd50);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_baseline;
    t_basic;
    t_hold;
    t_wrap;
    t_stamp_base;
    t_idle;
    t_zero_stamp;
    t_sat;
    t_ignore;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule